// File: doc/BRIEF.md
# Hashed Page Table Search Engine

This block resolves a virtual page to a real page by walking an in-memory hashed page table. It is started with a segment identifier, the segment's two protection key bits, the privilege flag, a 16-bit page index, the table configuration word and a read/write flag. From these it derives the primary hash and the address of an eight-slot entry group. It reads that group, one 32-bit word per cycle, over a simple memory port with a read latency of one cycle. Each slot is two words. If no slot in the primary group matches, the walk repeats the scan in the secondary group, which is found from the complemented hash.

When a slot matches, the engine checks every further match in the same group for agreement with the first one. It then decodes the page protection bits against the selected key and decides whether the access is granted. The referenced bit, and the changed bit on a granted write, are set in the first matching entry's second word, and that word is written back to memory. The engine returns the real page number and the effective read and write permissions with a one-cycle done pulse and a status code. Write permission is withheld while the changed bit is still clear, so that the first store to a page is forced to come back through the engine.

Top module: `hpt_walker`

## Requirements
- R1: The group base is (cfg & 0xFFFF0000) | (hash & mask), where mask = (cfg[8:0] << 16) | 0xFFC0 and the primary hash = ((vsid XOR page_idx) & 0x7FFFF) << 6. The first read of every search is at the primary group base.
- R2: The secondary hash is (NOT primary hash) & 0x01FFFFC0. The secondary group is read only when the primary group holds no matching entry, so a search issues 16 reads or 32 reads.
- R3: Slot i occupies word 0 at base+8i and word 1 at base+8i+4. A slot matches only if word-0 bit 31 is 1, word-0 bit 6 equals the pass (0 primary, 1 secondary), and (word 0 & 0x7FFFFFBF) equals (vsid << 7) | (page_idx >> 10).
- R4: All matches within a group must agree on word-1 bits 0xFFFFF07B. If any match disagrees, the status is 3 (conflict) and nothing is written.
- R5: The key is seg_kp when prob_state is 1 and seg_ks otherwise. Protection field = word-1 bits 1:0. With key 0, reads are always allowed and writes are allowed unless the field is 3. With key 1, field 0 gives no access, fields 1 and 3 give read-only, and field 2 gives read/write.
- R6: Status is 0 (hit) when the requested access is allowed, 2 (protection) when a match exists but the access is not allowed, and 1 (not found) after both groups hold no match.
- R7: On hit or protection, word-1 bit 8 (referenced) is set, and bit 7 (changed) is set on a granted write. The updated word is written to base+8g+4 of the first matching slot g only when it differs from the stored value. The write is the last memory operation of the search.
- R8: perm_w is 1 only if the key and protection field allow writes and the changed bit was already set or is set by this access. perm_r follows the decoded read right.
- R9: On hit or protection, rpn is word-1 bits 31:12 of the first matching slot. On not-found or conflict, rpn, perm_r and perm_w are 0.
- R10: Within a group scan, reads are issued on consecutive cycles at addresses increasing by 4. No read and write occur together. done is high for exactly one cycle per search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search; sampled when idle |
| vsid | input | 24 | Segment identifier |
| seg_ks | input | 1 | Supervisor key bit of the segment |
| seg_kp | input | 1 | User key bit of the segment |
| prob_state | input | 1 | 1 for user privilege, selects seg_kp |
| page_idx | input | 16 | Page index inside the segment |
| table_cfg | input | 32 | Table origin (bits 31:16) and hash mask extension (bits 8:0) |
| is_write | input | 1 | 1 for a store access |
| mem_addr | output | 32 | Memory byte address |
| mem_rd | output | 1 | Read request; data returns the next cycle |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after mem_rd |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 hit, 1 not found, 2 protection, 3 conflict |
| rpn | output | 20 | Real page number |
| perm_r | output | 1 | Effective read permission |
| perm_w | output | 1 | Effective write permission |

## Verification
The hardest cases to reach from the ports are two duplicate matches in one group, whether they agree or disagree, and a primary-group slot that carries the right tag but the wrong pass bit, which must be skipped in favour of a secondary hit. Random tags almost never produce these. The bench therefore computes both group addresses itself and plants entries at chosen slots of its memory model, with the other slots filled with random words. Random keys, protection fields, referenced and changed bits, and access directions then cover all combinations of grant, withheld write permission and write-back.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  typedef enum logic [1:0] {
    ST_HIT      = 2'd0,
    ST_MISS     = 2'd1,
    ST_PROT     = 2'd2,
    ST_CONFLICT = 2'd3
  } walk_status_e;

  localparam logic [31:0] TAG_MASK   = 32'h7FFF_FFBF;
  localparam logic [31:0] AGREE_MASK = 32'hFFFF_F07B;
  localparam int          REF_BIT    = 8;
  localparam int          CHG_BIT    = 7;
  localparam int          VALID_BIT  = 31;
  localparam int          SEL_BIT    = 6;
endpackage

// File: rtl/hpt_group_addr.sv
module hpt_group_addr #(
  parameter int VSID_W = 24,
  parameter int PIDX_W = 16
) (
  input  logic [VSID_W-1:0] vsid,
  input  logic [PIDX_W-1:0] page_idx,
  input  logic [31:0]       table_cfg,
  input  logic              sel,
  output logic [31:0]       group_base
);
  logic [31:0] mix, h_pri, h_sec, gmask;

  assign mix        = 32'(vsid) ^ 32'(page_idx);
  assign h_pri      = (mix & 32'h0007_FFFF) << 6;
  assign h_sec      = ~h_pri & 32'h01FF_FFC0;
  assign gmask      = {7'd0, table_cfg[8:0], 16'hFFC0};
  assign group_base = (table_cfg & 32'hFFFF_0000) | ((sel ? h_sec : h_pri) & gmask);
endmodule

// File: rtl/hpt_entry_match.sv
module hpt_entry_match
  import hpt_pkg::*;
#(
  parameter int VSID_W = 24,
  parameter int PIDX_W = 16
) (
  input  logic [31:0]       word0,
  input  logic              sel,
  input  logic [VSID_W-1:0] vsid,
  input  logic [PIDX_W-1:0] page_idx,
  output logic              hit
);
  logic [31:0] tag;

  assign tag = (32'(vsid) << 7) | 32'(page_idx >> 10);
  assign hit = word0[VALID_BIT] && (word0[SEL_BIT] == sel) && ((word0 & TAG_MASK) == tag);
endmodule

// File: rtl/hpt_access.sv
module hpt_access (
  input  logic       key,
  input  logic [1:0] pp,
  output logic       can_r,
  output logic       can_w
);
  always_comb begin
    if (!key) begin
      can_r = 1'b1;
      can_w = (pp != 2'd3);
    end else begin
      unique case (pp)
        2'd0:    begin can_r = 1'b0; can_w = 1'b0; end
        2'd2:    begin can_r = 1'b1; can_w = 1'b1; end
        default: begin can_r = 1'b1; can_w = 1'b0; end
      endcase
    end
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int VSID_W = 24,
  parameter int PIDX_W = 16,
  parameter int SLOTS  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [VSID_W-1:0] vsid,
  input  logic              seg_ks,
  input  logic              seg_kp,
  input  logic              prob_state,
  input  logic [PIDX_W-1:0] page_idx,
  input  logic [31:0]       table_cfg,
  input  logic              is_write,
  output logic [31:0]       mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              done,
  output logic [1:0]        status,
  output logic [19:0]       rpn,
  output logic              perm_r,
  output logic              perm_w
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int WORDS  = 2 * SLOTS;
  localparam int IDX_W  = $clog2(WORDS);
  localparam int CNT_W  = IDX_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_DECIDE, S_STORE} state_e;

  state_e            state_q;
  logic [VSID_W-1:0] vsid_q;
  logic [PIDX_W-1:0] pidx_q;
  logic [31:0]       cfg_q;
  logic              wr_q, key_q, pass_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              rv_q;
  logic [IDX_W-1:0]  ri_q;
  logic [31:0]       w0_q, keep_q, st_data_q;
  logic              found_q, clash_q;
  logic [SLOT_W-1:0] good_q;
  logic              done_q, pr_q, pw_q;
  logic [1:0]        status_q;
  logic [19:0]       rpn_q;

  logic [31:0] grp_base;
  logic        ent_hit, can_r, can_w, grant, eff_w, issue;
  logic [31:0] new_w1;

  hpt_group_addr #(.VSID_W(VSID_W), .PIDX_W(PIDX_W)) u_addr (
    .vsid(vsid_q), .page_idx(pidx_q), .table_cfg(cfg_q), .sel(pass_q), .group_base(grp_base)
  );

  hpt_entry_match #(.VSID_W(VSID_W), .PIDX_W(PIDX_W)) u_match (
    .word0(w0_q), .sel(pass_q), .vsid(vsid_q), .page_idx(pidx_q), .hit(ent_hit)
  );

  hpt_access u_acc (.key(key_q), .pp(keep_q[1:0]), .can_r(can_r), .can_w(can_w));

  assign issue  = (state_q == S_SCAN) && (cnt_q < CNT_W'(WORDS));
  assign grant  = wr_q ? can_w : can_r;
  assign eff_w  = can_w && (keep_q[CHG_BIT] || (wr_q && grant));
  assign new_w1 = keep_q | (32'd1 << REF_BIT) | ((wr_q && grant) ? (32'd1 << CHG_BIT) : 32'd0);

  assign mem_rd    = issue;
  assign mem_wr    = (state_q == S_STORE);
  assign mem_wdata = st_data_q;
  assign mem_addr  = (state_q == S_STORE) ? grp_base + (32'(good_q) << 3) + 32'd4
                                          : grp_base + (32'(cnt_q) << 2);

  assign done   = done_q;
  assign status = status_q;
  assign rpn    = rpn_q;
  assign perm_r = pr_q;
  assign perm_w = pw_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      vsid_q    <= '0;
      pidx_q    <= '0;
      cfg_q     <= '0;
      wr_q      <= 1'b0;
      key_q     <= 1'b0;
      pass_q    <= 1'b0;
      cnt_q     <= '0;
      rv_q      <= 1'b0;
      ri_q      <= '0;
      w0_q      <= '0;
      keep_q    <= '0;
      st_data_q <= '0;
      found_q   <= 1'b0;
      clash_q   <= 1'b0;
      good_q    <= '0;
      done_q    <= 1'b0;
      status_q  <= ST_HIT;
      rpn_q     <= '0;
      pr_q      <= 1'b0;
      pw_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      rv_q   <= issue;
      ri_q   <= cnt_q[IDX_W-1:0];
      unique case (state_q)
        S_IDLE: begin
          if (start) begin
            vsid_q  <= vsid;
            pidx_q  <= page_idx;
            cfg_q   <= table_cfg;
            wr_q    <= is_write;
            key_q   <= prob_state ? seg_kp : seg_ks;
            pass_q  <= 1'b0;
            cnt_q   <= '0;
            found_q <= 1'b0;
            clash_q <= 1'b0;
            state_q <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (issue) cnt_q <= cnt_q + 1'b1;
          if (rv_q) begin
            if (!ri_q[0]) begin
              w0_q <= mem_rdata;
            end else if (ent_hit) begin
              if (!found_q) begin
                found_q <= 1'b1;
                keep_q  <= mem_rdata;
                good_q  <= ri_q[IDX_W-1:1];
              end else if (((keep_q ^ mem_rdata) & AGREE_MASK) != 32'd0) begin
                clash_q <= 1'b1;
              end
            end
            if (ri_q == IDX_W'(WORDS - 1)) state_q <= S_DECIDE;
          end
        end
        S_DECIDE: begin
          if (clash_q) begin
            status_q <= ST_CONFLICT;
            rpn_q    <= '0;
            pr_q     <= 1'b0;
            pw_q     <= 1'b0;
            done_q   <= 1'b1;
            state_q  <= S_IDLE;
          end else if (!found_q) begin
            if (!pass_q) begin
              pass_q  <= 1'b1;
              cnt_q   <= '0;
              state_q <= S_SCAN;
            end else begin
              status_q <= ST_MISS;
              rpn_q    <= '0;
              pr_q     <= 1'b0;
              pw_q     <= 1'b0;
              done_q   <= 1'b1;
              state_q  <= S_IDLE;
            end
          end else begin
            status_q  <= grant ? ST_HIT : ST_PROT;
            rpn_q     <= keep_q[31:12];
            pr_q      <= can_r;
            pw_q      <= eff_w;
            st_data_q <= new_w1;
            if (new_w1 != keep_q) begin
              state_q <= S_STORE;
            end else begin
              done_q  <= 1'b1;
              state_q <= S_IDLE;
            end
          end
        end
        S_STORE: begin
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] mem_addr,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [31:0] mem_wdata,
  input logic        done,
  input logic [1:0]  status,
  input logic [19:0] rpn,
  input logic        perm_r,
  input logic        perm_w
);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  p_rw_excl_r10: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr));

  p_addr_step_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + 32'd4));

  p_store_word1_r7: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (mem_wdata[8] && mem_addr[2:0] == 3'b100));

  p_store_last_r7: assert property (@(posedge clk) disable iff (rst) mem_wr |=> done);

  p_quiet_fail_r9: assert property (@(posedge clk) disable iff (rst)
    (done && (status == 2'd1 || status == 2'd3)) |-> (rpn == 20'd0 && !perm_r && !perm_w));

  p_hit_readable_r6: assert property (@(posedge clk) disable iff (rst)
    (done && status == 2'd0) |-> perm_r);
endmodule

bind hpt_walker hpt_walker_chk u_chk (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_wdata(mem_wdata), .done(done), .status(status), .rpn(rpn),
  .perm_r(perm_r), .perm_w(perm_w)
);

// File: tb/tb_hpt_walker.sv
module tb_hpt_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [23:0] vsid = '0;
  logic        seg_ks = 1'b0, seg_kp = 1'b0, prob_state = 1'b0, is_write = 1'b0;
  logic [15:0] page_idx = '0;
  logic [31:0] table_cfg = '0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr, done, perm_r, perm_w;
  logic [1:0]  status;
  logic [19:0] rpn;

  always #10 clk = ~clk;

  hpt_walker dut (
    .clk(clk), .rst(rst), .start(start), .vsid(vsid), .seg_ks(seg_ks), .seg_kp(seg_kp),
    .prob_state(prob_state), .page_idx(page_idx), .table_cfg(table_cfg), .is_write(is_write),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done(done), .status(status), .rpn(rpn),
    .perm_r(perm_r), .perm_w(perm_w)
  );

  logic [31:0] mem [int unsigned];
  int n_vec = 0, n_bad = 0;
  int nreads = 0, nwrites = 0;
  logic [31:0] first_ra = '0, last_wa = '0, last_wd = '0;

  function automatic logic [31:0] rdw(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= rdw(mem_addr);
      if (nreads == 0) first_ra = mem_addr;
      nreads++;
    end
    if (mem_wr) begin
      mem[mem_addr] = mem_wdata;
      last_wa = mem_addr;
      last_wd = mem_wdata;
      nwrites++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] gbase(input logic [23:0] v, input logic [15:0] p,
                                        input logic [31:0] c, input bit sec);
    logic [31:0] h;
    h = ((32'(v) ^ 32'(p)) & 32'h7FFFF) << 6;
    if (sec) h = ~h & 32'h01FFFFC0;
    return (c & 32'hFFFF0000) | (h & ({16'd0, 7'd0, c[8:0]} << 16 | 32'hFFC0));
  endfunction

  // expected results
  logic [1:0]  e_status;
  logic [19:0] e_rpn;
  logic        e_r, e_w, e_wr;
  logic [31:0] e_waddr, e_wdata;
  int          e_reads;

  task automatic model();
    logic [31:0] b, w0, w1, keep, tag, nw;
    bit found, clash, key, ar, aw, gr;
    int good;
    tag = (32'(vsid) << 7) | 32'(page_idx >> 10);
    key = prob_state ? seg_kp : seg_ks;
    e_reads = 0; e_wr = 0; e_waddr = 0; e_wdata = 0;
    e_status = 2'd1; e_rpn = 0; e_r = 0; e_w = 0;
    found = 0; clash = 0; good = 0; keep = 0; b = 0;
    for (int pass = 0; pass < 2; pass++) begin
      b = gbase(vsid, page_idx, table_cfg, pass[0]);
      for (int i = 0; i < 8; i++) begin
        w0 = rdw(b + 32'(8 * i));
        w1 = rdw(b + 32'(8 * i + 4));
        if (w0[31] && w0[6] == pass[0] && (w0 & 32'h7FFFFFBF) == tag) begin
          if (!found) begin found = 1; keep = w1; good = i; end
          else if (((keep ^ w1) & 32'hFFFFF07B) != 0) clash = 1;
        end
      end
      e_reads += 16;
      if (found || clash) break;
    end
    if (clash) e_status = 2'd3;
    else if (found) begin
      if (!key) begin ar = 1; aw = (keep[1:0] != 2'd3); end
      else begin ar = (keep[1:0] != 2'd0); aw = (keep[1:0] == 2'd2); end
      gr = is_write ? aw : ar;
      e_status = gr ? 2'd0 : 2'd2;
      e_rpn = keep[31:12];
      e_r = ar;
      e_w = aw && (keep[7] || (is_write && gr));
      nw = keep | 32'h100 | ((is_write && gr) ? 32'h80 : 32'h0);
      e_wr = (nw != keep);
      e_waddr = b + 32'(8 * good + 4);
      e_wdata = nw;
    end
  endtask

  function automatic logic [31:0] mk_w1(input logic [19:0] r, input bit rb, input bit cb,
                                        input logic [1:0] pp);
    return {r, 3'b000, rb, cb, 4'($urandom), 1'b0, pp};
  endfunction

  task automatic plant(input logic [31:0] b, input int slot, input bit sel, input logic [31:0] w1);
    mem[b + 32'(8 * slot)]     = {1'b1, vsid, sel, page_idx[15:10]};
    mem[b + 32'(8 * slot + 4)] = w1;
  endtask

  task automatic run_case(input int scen, input bit ks, input bit kp, input bit pr, input bit wr,
                          input logic [1:0] pp, input bit rb, input bit cb, input string tag);
    logic [31:0] pb, sb, w1;
    int s0, s1;
    bit got;
    mem.delete();
    vsid = 24'($urandom); page_idx = 16'($urandom);
    table_cfg = {16'($urandom), 7'd0, 9'($urandom % 4)};
    seg_ks = ks; seg_kp = kp; prob_state = pr; is_write = wr;
    pb = gbase(vsid, page_idx, table_cfg, 0);
    sb = gbase(vsid, page_idx, table_cfg, 1);
    for (int i = 0; i < 16; i++) begin
      mem[pb + 32'(4 * i)] = $urandom;
      mem[sb + 32'(4 * i)] = $urandom;
    end
    s0 = int'($urandom % 4); s1 = 4 + int'($urandom % 4);
    w1 = mk_w1(20'($urandom), rb, cb, pp);
    case (scen)
      1: plant(pb, s0, 0, w1);
      2: plant(sb, s0, 1, w1);
      3: begin plant(pb, s0, 0, w1); plant(pb, s1, 0, w1 ^ 32'h184); end
      4: begin plant(pb, s0, 0, w1); plant(pb, s1, 0, w1 ^ 32'h1000); end
      5: begin plant(pb, s0, 1, w1 ^ 32'h5000); plant(sb, s1, 1, w1); end
      6: begin plant(sb, s0, 1, w1); plant(sb, s1, 1, w1 ^ 32'h2); end
      default: ;
    endcase
    model();
    nreads = 0; nwrites = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    got = 0;
    for (int c = 0; c < 100; c++) begin
      if (done) begin got = 1; break; end
      @(negedge clk);
    end
    chk(got, "R10", {tag, " done seen"}, 32'(got), 32'd1);
    if (got) begin
      chk(status == e_status, "R6", {tag, " status"}, 32'(status), 32'(e_status));
      chk(rpn == e_rpn, "R9", {tag, " rpn"}, 32'(rpn), 32'(e_rpn));
      chk(perm_r == e_r, "R5", {tag, " perm_r"}, 32'(perm_r), 32'(e_r));
      chk(perm_w == e_w, "R8", {tag, " perm_w"}, 32'(perm_w), 32'(e_w));
      chk(first_ra == pb, "R1", {tag, " first read address"}, first_ra, pb);
      chk(nreads == e_reads, "R2", {tag, " read count"}, 32'(nreads), 32'(e_reads));
      chk(nwrites == int'(e_wr), "R7", {tag, " write count"}, 32'(nwrites), 32'(e_wr));
      if (e_wr) begin
        chk(last_wa == e_waddr, "R7", {tag, " write address"}, last_wa, e_waddr);
        chk(rdw(e_waddr) == e_wdata, "R7", {tag, " written word"}, rdw(e_waddr), e_wdata);
      end
      @(negedge clk);
      chk(!done, "R10", {tag, " done one cycle"}, 32'(done), 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(!done && !mem_rd && !mem_wr, "R10", "reset quiet", {29'd0, done, mem_rd, mem_wr}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    // directed corners
    run_case(0, 0, 0, 0, 0, 2'd0, 0, 0, "R2 miss both groups");
    run_case(1, 0, 0, 0, 0, 2'd3, 0, 0, "R8 read withholds write");
    run_case(1, 0, 0, 0, 1, 2'd3, 1, 1, "R5 key0 pp3 write");
    run_case(1, 0, 1, 1, 0, 2'd0, 1, 1, "R5 key1 pp0 read");
    run_case(1, 1, 0, 0, 1, 2'd2, 0, 0, "R5 key1 pp2 write");
    run_case(1, 0, 0, 0, 0, 2'd1, 1, 1, "R7 no store needed");
    run_case(2, 0, 0, 0, 1, 2'd0, 1, 0, "R2 secondary hit");
    run_case(3, 0, 0, 0, 1, 2'd2, 0, 0, "R4 agreeing duplicates");
    run_case(4, 0, 0, 0, 0, 2'd2, 0, 0, "R4 disagreeing duplicates");
    run_case(5, 0, 0, 0, 0, 2'd1, 0, 0, "R3 wrong select bit skipped");
    run_case(6, 1, 1, 1, 1, 2'd1, 0, 1, "R4 secondary conflict");
    for (int n = 0; n < 300; n++)
      run_case(int'($urandom % 7), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               2'($urandom), 1'($urandom), 1'($urandom), "random");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule